// File: doc/BRIEF.md
# Serial Display Link Training Sequencer

This block runs the two-phase bring-up of a high-speed serial display link. Phase one is clock recovery and phase two is channel equalization. A single start pulse launches the run. The sequencer drives the local training-pattern generator and the local drive levels. Over an abstract sideband register port it programs the sink's pattern selector and its four per-lane drive bytes. It reads the sink's lane status and adjustment requests, applies the requested levels, counts retries, and reports the outcome of each phase when it finishes.

The sideband port is a request/acknowledge handshake. While `sb_req` is high, address, direction and write data are held steady. A transaction completes in the cycle where `sb_ack` is high. Read data is taken from `sb_rdata` in that same cycle.

The sequencer waits a fixed time before every status read. The wait is set by parameters: 100 µs for clock recovery and 400 µs for equalization, scaled by `CLK_MHZ`. An asserted abort input ends the current phase with failure. The check is made at the top of every training round.

Top module: `link_train_seq`

## Requirements
- R1: Clock recovery begins by holding the local pattern `pat_sel` at 0 (off) and then selecting 1. The sink pattern register (address 0x102) is then written with 0x21, which is pattern 1 (bits [1:0]) with the scrambling-off flag (bit 5).
- R2: Equalization begins with `pat_sel` at 0. The drive bytes are written to the sink first. Then `pat_sel` becomes 3 when `tps3_ok` is high, otherwise 2. Register 0x102 is then written with that pattern plus the recovered-clock flag (bit 4), giving 0x13 or 0x12.
- R3: Every drive update writes the same byte to addresses 0x103, 0x104, 0x105 and 0x106, in that order. The byte holds swing in [1:0] and pre-emphasis in [4:3]. Bit 2 is set when swing is 3 and bit 5 is set when pre-emphasis is 3. The other bits are 0. `drv_swing` and `drv_pre` follow the same levels.
- R4: A status read covers 0x202, 0x203, 0x204, 0x206 and 0x207. Lane n's status nibble is bits [4n+3:4n] of {0x203, 0x202}: bit 0 means clock locked, bit 1 means equalized, bit 2 means symbol locked. Clock recovery passes when bit 0 is set on every lane below `lane_cnt`. Inactive lanes are ignored.
- R5: When clock recovery fails a round at an unchanged swing, a retry counter increments. A swing change since the last round resets the counter to 0. Failing for the fifth time at the same swing ends the phase with failure. Otherwise the sink's requested levels are applied: lane n's nibble of {0x207, 0x206} gives swing in [1:0] and pre-emphasis in [3:2], and the maximum over the active lanes is used. New drive bytes are then written.
- R6: If clock recovery is not achieved while swing is already 3, the phase fails at once.
- R7: Equalization passes when status bits 0, 1 and 2 are set on every active lane and the lane-align bit (bit 0 of 0x204) is set. After seven unsuccessful rounds, which involve six level adjustments, the phase fails.
- R8: While bit 7 of 0x204 (status updated) is set, the whole status read is repeated, up to 100 reads per round. The last read is then evaluated.
- R9: Each run starts at swing 0 and pre-emphasis 0. On success or failure it ends by setting `pat_sel` to 0 and writing 0x00 to 0x102. `pat_sel` is 0 whenever the block is idle.
- R10: If `abort` is high at the top of a round, the current phase ends in failure without a status read.
- R11: After reset the block is idle, with no request and all flags low. When a run ends, `done` pulses for one cycle and `busy` falls. `cr_ok` and `eq_ok` hold the phase outcomes until the next start. `eq_ok` is never set without `cr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a training run while idle |
| abort | input | 1 | Ends the current phase with failure at the next round |
| lane_cnt | input | 3 | Number of active lanes (1, 2 or 4) |
| tps3_ok | input | 1 | Sink supports pattern 3 for equalization |
| sb_req | output | 1 | Sideband transaction request |
| sb_wr | output | 1 | 1 = write, 0 = read |
| sb_addr | output | 10 | Sink register address |
| sb_wdata | output | 8 | Write data |
| sb_ack | input | 1 | Transaction complete |
| sb_rdata | input | 8 | Read data, valid with `sb_ack` |
| pat_sel | output | 2 | Local pattern generator selection, 0 = off |
| drv_swing | output | 2 | Local swing level |
| drv_pre | output | 2 | Local pre-emphasis level |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cr_ok | output | 1 | Clock recovery succeeded in the last run |
| eq_ok | output | 1 | Equalization succeeded in the last run |

## Verification
The sink model is driven with nine configurations:
- Everything locked on the first read.
- One lane that never recovers clock at a fixed request, which separates the five-retry timeout from the immediate failure at maximum swing.
- A request for maximum levels, which shows the flag bits in the drive byte and the early exit.
- A lane that never equalizes, and a missing lane-align bit, which show the seven-round equalization budget.
- Narrow lane counts with dead upper lanes, which show that inactive lanes are masked.
- A status-updated flag held for three reads, and one held forever, which show the re-read and its 100-read cap.
- An early abort.

For each run, the counts of status reads and drive writes, the order and values of the pattern writes, the sequence of local pattern changes, and the last and first drive bytes together distinguish each of these paths from the others.

// File: rtl/link_train_seq.sv
module link_train_seq #(
  parameter int CLK_MHZ    = 100,
  parameter int CR_US      = 100,
  parameter int EQ_US      = 400,
  parameter int CR_TRIES   = 5,
  parameter int EQ_TRIES   = 5,
  parameter int STAT_TRIES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [2:0] lane_cnt,
  input  logic       tps3_ok,
  output logic       sb_req,
  output logic       sb_wr,
  output logic [9:0] sb_addr,
  output logic [7:0] sb_wdata,
  input  logic       sb_ack,
  input  logic [7:0] sb_rdata,
  output logic [1:0] pat_sel,
  output logic [1:0] drv_swing,
  output logic [1:0] drv_pre,
  output logic       busy,
  output logic       done,
  output logic       cr_ok,
  output logic       eq_ok
);
  localparam int CR_CYC = CR_US * CLK_MHZ;
  localparam int EQ_CYC = EQ_US * CLK_MHZ;
  localparam int WW = $clog2((EQ_CYC > CR_CYC ? EQ_CYC : CR_CYC) + 1);
  localparam int TW = $clog2(CR_TRIES + EQ_TRIES + 2);
  localparam int AW = $clog2(STAT_TRIES + 1);
  localparam logic [TW-1:0] CR_LIM  = TW'(CR_TRIES - 1);
  localparam logic [TW-1:0] EQ_LIM  = TW'(EQ_TRIES);
  localparam logic [AW-1:0] ATT_LIM = AW'(STAT_TRIES - 1);
  localparam logic [9:0] A_PAT  = 10'h102;
  localparam logic [9:0] A_DRV  = 10'h103;
  localparam logic [9:0] A_STAT = 10'h202;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_PAT, S_PWR, S_DRV, S_LOOP, S_WAIT, S_RD, S_EVAL, S_END, S_EWR
  } st_t;

  st_t           st;
  logic          phase, setup, done_r, cr_r, eq_r;
  logic [2:0]    idx;
  logic [WW-1:0] wcnt;
  logic [TW-1:0] tries;
  logic [AW-1:0] att;
  logic [1:0]    sw, pre, old_sw, pat;
  logic [7:0]    stat [5];
  logic [15:0]   lst, rqs;
  logic [3:0]    act;
  logic          cr_all, eq_all;
  logic [1:0]    mx_sw, mx_pre;
  logic [7:0]    drv_byte;

  assign lst      = {stat[1], stat[0]};
  assign rqs      = {stat[4], stat[3]};
  assign drv_byte = {2'b00, pre == 2'd3, pre, sw == 2'd3, sw};

  always_comb begin
    cr_all = 1'b1;
    eq_all = stat[2][0];
    mx_sw  = 2'd0;
    mx_pre = 2'd0;
    for (int i = 0; i < 4; i++) begin
      act[i] = lane_cnt > 3'(i);
      if (act[i]) begin
        cr_all = cr_all & lst[4*i];
        eq_all = eq_all & (lst[4*i +: 3] == 3'b111);
        if (rqs[4*i +: 2] > mx_sw)    mx_sw  = rqs[4*i +: 2];
        if (rqs[4*i+2 +: 2] > mx_pre) mx_pre = rqs[4*i+2 +: 2];
      end
    end
  end

  assign sb_req = (st == S_PWR) || (st == S_DRV) || (st == S_RD) || (st == S_EWR);
  assign sb_wr  = (st != S_RD);

  always_comb begin
    case (st)
      S_DRV:   sb_addr = A_DRV + {7'd0, idx};
      S_RD:    sb_addr = A_STAT + {7'd0, idx} + {9'd0, idx >= 3'd3};
      default: sb_addr = A_PAT;
    endcase
    case (st)
      S_PWR:   sb_wdata = {2'b00, ~phase, phase, 2'b00, pat};
      S_DRV:   sb_wdata = drv_byte;
      default: sb_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= 1'b0; setup <= 1'b0; done_r <= 1'b0;
      cr_r <= 1'b0; eq_r <= 1'b0; idx <= '0; wcnt <= '0; tries <= '0;
      att <= '0; sw <= '0; pre <= '0; old_sw <= '0; pat <= '0;
      for (int k = 0; k < 5; k++) stat[k] <= '0;
    end else begin
      done_r <= (st == S_EWR) && sb_ack;
      case (st)
        S_IDLE: if (start) begin
          sw <= '0; pre <= '0; old_sw <= '0; tries <= '0; phase <= 1'b0;
          cr_r <= 1'b0; eq_r <= 1'b0; st <= S_CLR;
        end
        S_CLR: begin
          pat <= '0; setup <= 1'b1; idx <= '0;
          st <= phase ? S_DRV : S_PAT;
        end
        S_PAT: begin
          pat <= phase ? (tps3_ok ? 2'd3 : 2'd2) : 2'd1;
          setup <= 1'b0; st <= S_PWR;
        end
        S_PWR: if (sb_ack) begin
          idx <= '0; st <= phase ? S_LOOP : S_DRV;
        end
        S_DRV: if (sb_ack) begin
          if (idx == 3'd3) begin
            idx <= '0; st <= (phase && setup) ? S_PAT : S_LOOP;
          end else idx <= idx + 3'd1;
        end
        S_LOOP: begin
          att <= '0; idx <= '0;
          wcnt <= phase ? WW'(EQ_CYC) : WW'(CR_CYC);
          st <= abort ? S_END : S_WAIT;
        end
        S_WAIT: if (wcnt == '0) st <= S_RD; else wcnt <= wcnt - 1'b1;
        S_RD: if (sb_ack) begin
          stat[idx] <= sb_rdata;
          if (idx == 3'd4) begin idx <= '0; st <= S_EVAL; end
          else idx <= idx + 3'd1;
        end
        S_EVAL: begin
          if (stat[2][7] && att < ATT_LIM) begin
            att <= att + 1'b1; st <= S_RD;
          end else if (!phase) begin
            if (cr_all) begin
              cr_r <= 1'b1; phase <= 1'b1; tries <= '0; st <= S_CLR;
            end else if (sw == 2'd3 || (sw == old_sw && tries >= CR_LIM)) st <= S_END;
            else begin
              if (sw == old_sw) tries <= tries + 1'b1;
              else begin tries <= '0; old_sw <= sw; end
              sw <= mx_sw; pre <= mx_pre; st <= S_DRV;
            end
          end else begin
            if (eq_all) begin eq_r <= 1'b1; st <= S_END; end
            else if (tries > EQ_LIM) st <= S_END;
            else begin
              tries <= tries + 1'b1; sw <= mx_sw; pre <= mx_pre; st <= S_DRV;
            end
          end
        end
        S_END: begin pat <= '0; st <= S_EWR; end
        S_EWR: if (sb_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pat_sel   = pat;
  assign drv_swing = sw;
  assign drv_pre   = pre;
  assign busy      = (st != S_IDLE);
  assign done      = done_r;
  assign cr_ok     = cr_r;
  assign eq_ok     = eq_r;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack) |=> (sb_req && $stable(sb_addr) && $stable(sb_wdata) && $stable(sb_wr)));
  p_eq_after_cr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eq_ok |-> cr_ok);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pat_sel == 2'd0 && !sb_req));
  p_cr_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> (tries < TW'(CR_TRIES)));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOP && abort) |=> (st == S_END));
endmodule

// File: tb/link_train_seq_tb_top.sv
module link_train_seq_tb_top;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [2:0]  lanes;
    logic        tps3;
    logic [3:0]  crm;
    logic [3:0]  eqm;
    logic        al;
    logic [3:0]  req;
    logic [7:0]  upd;
    logic        ab;
    logic        xcr;
    logic        xeq;
    logic [11:0] xrd;
    logic [7:0]  xdrv;
    logic [7:0]  xpat2;
    logic [7:0]  xlast;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{3'd4, 1'b1, 4'hF, 4'hF, 1'b1, 4'h0, 8'd0,   1'b0, 1'b1, 1'b1, 12'd10,   8'd8,  8'h13, 8'h00},
    '{3'd4, 1'b0, 4'h7, 4'hF, 1'b1, 4'h0, 8'd0,   1'b0, 1'b0, 1'b0, 12'd25,   8'd20, 8'h00, 8'h00},
    '{3'd4, 1'b1, 4'h0, 4'h0, 1'b1, 4'hF, 8'd0,   1'b0, 1'b0, 1'b0, 12'd10,   8'd8,  8'h00, 8'h3F},
    '{3'd2, 1'b0, 4'h3, 4'h1, 1'b1, 4'h5, 8'd0,   1'b0, 1'b1, 1'b0, 12'd40,   8'd32, 8'h12, 8'h09},
    '{3'd1, 1'b1, 4'h1, 4'h1, 1'b1, 4'h0, 8'd0,   1'b0, 1'b1, 1'b1, 12'd10,   8'd8,  8'h13, 8'h00},
    '{3'd4, 1'b1, 4'hF, 4'hF, 1'b0, 4'h0, 8'd0,   1'b0, 1'b1, 1'b0, 12'd40,   8'd32, 8'h13, 8'h00},
    '{3'd4, 1'b1, 4'hF, 4'hF, 1'b1, 4'h0, 8'd3,   1'b0, 1'b1, 1'b1, 12'd25,   8'd8,  8'h13, 8'h00},
    '{3'd4, 1'b1, 4'hF, 4'hF, 1'b1, 4'h0, 8'd255, 1'b0, 1'b1, 1'b1, 12'd1000, 8'd8,  8'h13, 8'h00},
    '{3'd4, 1'b1, 4'hF, 4'hF, 1'b1, 4'h0, 8'd0,   1'b1, 1'b0, 1'b0, 12'd0,    8'd4,  8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, tps3_ok = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic sb_req, sb_wr, sb_ack = 1'b0;
  logic [9:0] sb_addr;
  logic [7:0] sb_wdata, sb_rdata = 8'h00;
  logic [1:0] pat_sel, drv_swing, drv_pre;
  logic busy, done, cr_ok, eq_ok;

  always #(PERIOD/2) clk = ~clk;

  link_train_seq #(.CLK_MHZ(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .lane_cnt(lane_cnt),
    .tps3_ok(tps3_ok), .sb_req(sb_req), .sb_wr(sb_wr), .sb_addr(sb_addr),
    .sb_wdata(sb_wdata), .sb_ack(sb_ack), .sb_rdata(sb_rdata), .pat_sel(pat_sel),
    .drv_swing(drv_swing), .drv_pre(drv_pre), .busy(busy), .done(done),
    .cr_ok(cr_ok), .eq_ok(eq_ok)
  );

  int checks = 0, fails = 0;
  logic [3:0] cfg_crm = 0, cfg_eqm = 0, cfg_req = 0;
  logic cfg_al = 0;
  int cfg_upd = 0, nupd = 0, nrd = 0, ndrv = 0, npw = 0, drv_err = 0, ndrv_pw1 = 0, nps = 0, lat = 0;
  logic [7:0] pw [4];
  logic [7:0] grp = 0, firstd = 0, lastd = 0;
  logic [1:0] ps [4];
  logic [1:0] prev_pat = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ln(int i);
    return {1'b0, cfg_eqm[i], cfg_eqm[i], cfg_crm[i]};
  endfunction

  task automatic serve();
    if (sb_wr) begin
      if (sb_addr == 10'h102) begin
        if (npw < 4) pw[npw] = sb_wdata;
        if (npw == 1) ndrv_pw1 = ndrv;
        npw++;
      end else begin
        if (sb_addr != 10'h103 + 10'(ndrv % 4)) drv_err++;
        if (ndrv % 4 == 0) grp = sb_wdata;
        else if (sb_wdata != grp) drv_err++;
        if (ndrv == 0) firstd = sb_wdata;
        lastd = sb_wdata;
        ndrv++;
      end
    end else begin
      nrd++;
      case (sb_addr)
        10'h202: sb_rdata = {ln(1), ln(0)};
        10'h203: sb_rdata = {ln(3), ln(2)};
        10'h204: begin sb_rdata = {nupd < cfg_upd, 6'd0, cfg_al}; nupd++; end
        10'h206, 10'h207: sb_rdata = {cfg_req, cfg_req};
        default: sb_rdata = 8'h00;
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin sb_ack = 1'b0; lat = 0; end
    else if (sb_ack) sb_ack = 1'b0;
    else if (sb_req) begin
      if (lat < 1) lat++;
      else begin lat = 0; sb_ack = 1'b1; serve(); end
    end else lat = 0;
    if (rst_n && pat_sel != prev_pat) begin
      if (nps < 4) ps[nps] = pat_sel;
      nps++;
      prev_pat = pat_sel;
    end
  end

  function automatic string otag(int v);
    case (v)
      0, 4:    return "R4";
      1:       return "R5";
      2:       return "R6";
      3, 5:    return "R7";
      6, 7:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic run(int v);
    vec_t t;
    int n;
    int xnpw;
    t = VT[v];
    cfg_crm = t.crm; cfg_eqm = t.eqm; cfg_al = t.al; cfg_req = t.req; cfg_upd = int'(t.upd);
    nupd = 0; nrd = 0; ndrv = 0; npw = 0; drv_err = 0; ndrv_pw1 = 0; nps = 0;
    for (int k = 0; k < 4; k++) begin pw[k] = 8'hEE; ps[k] = 2'd0; end
    lane_cnt = t.lanes; tps3_ok = t.tps3; abort = t.ab;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy during run", int'(busy), 1);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    abort = 1'b0;
    chk("R11 done seen", int'(n < 20000), 1);
    chk("R11 busy low at done", int'(busy), 0);
    chk({otag(v), " cr_ok"}, int'(cr_ok), int'(t.xcr));
    chk({otag(v), " eq_ok"}, int'(eq_ok), int'(t.xeq));
    chk("R8 status read count", nrd, int'(t.xrd));
    chk("R3 drive write count", ndrv, int'(t.xdrv));
    chk("R3 drive group order and data", drv_err, 0);
    chk("R3 last drive byte", int'(lastd), int'(t.xlast));
    chk("R3 local levels", int'({drv_pre, drv_swing}), int'({t.xlast[4:3], t.xlast[1:0]}));
    chk("R9 first drive byte zero levels", int'(firstd), 0);
    chk("R1 first pattern write", int'(pw[0]), 8'h21);
    xnpw = (t.xpat2 != 0) ? 3 : 2;
    chk("R9 pattern write count", npw, xnpw);
    chk("R9 final pattern write zero", int'(pw[xnpw-1]), 0);
    chk("R9 pat_sel idle", int'(pat_sel), 0);
    if (t.xpat2 != 0) begin
      chk("R2 phase two pattern write", int'(pw[1]), int'(t.xpat2));
      chk("R2 drive bytes before pattern", ndrv_pw1, 8);
      chk("R1 local pattern changes", nps, 4);
      chk("R2 local pattern order", int'({ps[0], ps[1], ps[2], ps[3]}),
          int'({2'd1, 2'd0, t.xpat2[1:0], 2'd0}));
    end else begin
      chk("R1 local pattern changes", nps, 2);
      chk("R1 local pattern order", int'({ps[0], ps[1]}), int'({2'd1, 2'd0}));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset req", int'(sb_req), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset flags", int'({cr_ok, eq_ok}), 0);
    chk("R9 reset pattern", int'(pat_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++) run(v);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule